// File: doc/BRIEF.md
# Five-Field Priority Rule Matcher

This block checks one packet header against a small table of classification rules and reports the best rule that matches. The header has five fields: an 8-bit source address, an 8-bit destination address, a 4-bit source port, a 4-bit destination port and a 2-bit protocol. Each field of a rule has its own kind of comparison. The two addresses are compared by prefix, the two ports by an inclusive range, and the protocol by an exact value that can be turned into a wildcard.

Every rule has a numeric priority. When several rules match, the priority decides the result and the position of the rule in the table does not. The smallest priority value wins. If two matching rules have the same value, the rule with the lower index wins.

Rules are written one at a time through a write port. Lookups enter with a valid/ready handshake and come out through a three-register pipeline. Backpressure on the output stalls the whole pipeline.

Top module: `mfm_matcher`

## Requirements
- R1: An address field matches when the top `len` bits of the header field equal the top `len` bits of the stored value. A length of 0 matches every value. Lengths from 9 to 15 act as 8.
- R2: A port field matches when low <= port <= high. A rule whose low bound is above its high bound never matches. The range [0:15] matches every port.
- R3: The protocol matches when it equals the stored value, or when the rule's protocol wildcard flag is 1.
- R4: A rule matches only when its enable bit is 1 and all five fields match. A rule whose enable bit is 0 never matches.
- R5: Among the matching rules, the result is the one with the smallest priority value. Ties go to the lower rule index.
- R6: `out_hit` is 1 when at least one rule matches. When no rule matches, `out_hit` is 0 and both `out_idx` and `out_prio` are 0.
- R7: A lookup accepted at clock edge k has its result on the outputs right after edge k+2, as long as `out_ready` stays 1. One lookup can be accepted every cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0:
  - `in_ready` is 0;
  - `out_hit`, `out_idx` and `out_prio` hold their values until the result is taken.
- R9: A write with `cfg_we`=1 replaces the whole entry `cfg_idx` at that clock edge. Any lookup accepted at that edge or later sees the new contents.
- R10: Synchronous active-low reset has these effects:
  - every rule is disabled;
  - `out_valid` goes to 0 and `in_ready` goes to 1;
  - a lookup that follows reports no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Rule write strobe |
| cfg_idx | input | 3 | Index of the rule to write |
| cfg_en | input | 1 | Enable bit of the written rule |
| cfg_sa | input | 8 | Source address prefix value |
| cfg_sa_len | input | 4 | Source address prefix length |
| cfg_da | input | 8 | Destination address prefix value |
| cfg_da_len | input | 4 | Destination address prefix length |
| cfg_sp_lo | input | 4 | Source port range, low bound |
| cfg_sp_hi | input | 4 | Source port range, high bound |
| cfg_dp_lo | input | 4 | Destination port range, low bound |
| cfg_dp_hi | input | 4 | Destination port range, high bound |
| cfg_proto | input | 2 | Protocol value |
| cfg_proto_any | input | 1 | Protocol wildcard flag |
| cfg_prio | input | 4 | Rule priority (smaller value wins) |
| in_valid | input | 1 | Lookup request valid |
| in_ready | output | 1 | Lookup request accepted when high with in_valid |
| in_sa | input | 8 | Header source address |
| in_da | input | 8 | Header destination address |
| in_sp | input | 4 | Header source port |
| in_dp | input | 4 | Header destination port |
| in_proto | input | 2 | Header protocol |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_hit | output | 1 | At least one rule matched |
| out_idx | output | 3 | Index of the winning rule |
| out_prio | output | 4 | Priority of the winning rule |

## Verification
The hardest case to reach from the ports is a full pipeline that stalls while several rules with equal priority match at once. That case tests both the hold behaviour and the tie-break rule. To reach it, the stimulus sends back-to-back requests while `out_ready` is randomly driven low. Rule priorities are drawn from only four values, so ties between matching rules happen often. Prefix lengths are kept short so that rules match often. Directed lookups cover the remaining corner cases:
- a higher-priority rule placed at a larger index than a lower-priority rule;
- an exact tie between two rules;
- a rule that has been disabled;
- an inverted port range;
- a prefix length above 8.

// File: rtl/mfm_pkg.sv
// Package mfm_pkg
// Purpose : field widths, header and rule record types shared by the matcher.
// Assumes : field widths are fixed by the header format; table size and
//           priority width are parameters of the modules that use them.
package mfm_pkg;

    localparam int ADDR_W  = 8;
    localparam int PORT_W  = 4;
    localparam int PROTO_W = 2;
    localparam int LEN_W   = $clog2(ADDR_W + 1);

    // One lookup key.
    typedef struct packed {
        logic [ADDR_W-1:0]  sa;
        logic [ADDR_W-1:0]  da;
        logic [PORT_W-1:0]  sp;
        logic [PORT_W-1:0]  dp;
        logic [PROTO_W-1:0] proto;
    } hdr_t;

    // One rule without its priority.
    typedef struct packed {
        logic               en;
        logic [ADDR_W-1:0]  sa;
        logic [LEN_W-1:0]   sa_len;
        logic [ADDR_W-1:0]  da;
        logic [LEN_W-1:0]   da_len;
        logic [PORT_W-1:0]  sp_lo;
        logic [PORT_W-1:0]  sp_hi;
        logic [PORT_W-1:0]  dp_lo;
        logic [PORT_W-1:0]  dp_hi;
        logic [PROTO_W-1:0] proto;
        logic               proto_any;
    } rule_t;

endpackage

// File: rtl/mfm_rule_table.sv
// Module mfm_rule_table
// Purpose : register file of NUM_RULES rules and their priorities,
//           written one whole entry per cycle.
// Assumes : indices at or above NUM_RULES are ignored; reset clears all
//           entries, so every rule starts disabled.
module mfm_rule_table
    import mfm_pkg::*;
#(
    parameter int NUM_RULES = 8,
    parameter int PRIO_W    = 4,
    parameter int IDX_W     = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  rule_t                             wr_rule,
    input  logic [PRIO_W-1:0]                 wr_prio,
    output rule_t [NUM_RULES-1:0]             rules_o,
    output logic  [NUM_RULES-1:0][PRIO_W-1:0] prio_o
);

    rule_t [NUM_RULES-1:0]             rules_q;
    logic  [NUM_RULES-1:0][PRIO_W-1:0] prio_q;

    // Store a whole entry on a write, clear the table on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rules_q <= '0;
            prio_q  <= '0;
        end else if (wr_en && (int'(wr_idx) < NUM_RULES)) begin
            rules_q[wr_idx] <= wr_rule;
            prio_q[wr_idx]  <= wr_prio;
        end
    end

    assign rules_o = rules_q;
    assign prio_o  = prio_q;

    // R9: a write lands in the addressed entry at that edge
    a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_idx) < NUM_RULES)) |=>
            (rules_q[$past(wr_idx)] == $past(wr_rule)) &&
            (prio_q[$past(wr_idx)] == $past(wr_prio)));

endmodule

// File: rtl/mfm_rule_cmp.sv
// Module mfm_rule_cmp
// Purpose : decides whether one rule covers one header; purely combinational.
// Assumes : prefix lengths above ADDR_W are treated as ADDR_W; an empty
//           (inverted) port range covers nothing.
module mfm_rule_cmp
    import mfm_pkg::*;
(
    input  hdr_t  hdr,
    input  rule_t rule,
    output logic  hit
);

    // Prefix test: build a mask of the leading len bits and compare under it.
    function automatic logic pfx_ok(input logic [ADDR_W-1:0] key,
                                    input logic [ADDR_W-1:0] val,
                                    input logic [LEN_W-1:0]  len);
        logic [ADDR_W-1:0] m;
        m = '0;
        for (int b = 0; b < ADDR_W; b++) begin
            if (int'(len) > b) m[ADDR_W-1-b] = 1'b1;
        end
        return ((key ^ val) & m) == '0;
    endfunction

    // Inclusive range test.
    function automatic logic rng_ok(input logic [PORT_W-1:0] key,
                                    input logic [PORT_W-1:0] lo,
                                    input logic [PORT_W-1:0] hi);
        return (key >= lo) && (key <= hi);
    endfunction

    logic sa_ok, da_ok, sp_ok, dp_ok, pr_ok;

    // Evaluate each field with its own comparison kind.
    always_comb begin
        sa_ok = pfx_ok(hdr.sa, rule.sa, rule.sa_len);
        da_ok = pfx_ok(hdr.da, rule.da, rule.da_len);
        sp_ok = rng_ok(hdr.sp, rule.sp_lo, rule.sp_hi);
        dp_ok = rng_ok(hdr.dp, rule.dp_lo, rule.dp_hi);
        pr_ok = rule.proto_any || (hdr.proto == rule.proto);
    end

    assign hit = rule.en && sa_ok && da_ok && sp_ok && dp_ok && pr_ok;

endmodule

// File: rtl/mfm_prio_sel.sv
// Module mfm_prio_sel
// Purpose : picks the matching rule with the smallest priority value, lowest
//           index on ties; outputs zero index and priority when none match.
// Assumes : clk and rst_n are used only by the local assertions.
module mfm_prio_sel #(
    parameter int NUM_RULES = 8,
    parameter int PRIO_W    = 4,
    parameter int IDX_W     = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_RULES-1:0]              hit_i,
    input  logic [NUM_RULES-1:0][PRIO_W-1:0]  prio_i,
    output logic                              found_o,
    output logic [IDX_W-1:0]                  idx_o,
    output logic [PRIO_W-1:0]                 prio_o
);

    // Scan upward; only a strictly smaller value displaces the holder.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        prio_o  = '0;
        for (int i = 0; i < NUM_RULES; i++) begin
            if (hit_i[i] && (!found_o || (prio_i[i] < prio_o))) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
                prio_o  = prio_i[i];
            end
        end
    end

    // R5: the reported rule is one that actually matched, with its own priority
    a_r5_winner_matched: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> (hit_i[idx_o] && (prio_o == prio_i[idx_o])));

    // R6: a result is found exactly when some rule matched
    a_r6_found_any: assert property (@(posedge clk) disable iff (!rst_n)
        found_o == (|hit_i));

endmodule

// File: rtl/mfm_matcher.sv
// Module mfm_matcher
// Purpose : top of the five-field priority rule matcher. Three register
//           stages: header capture, per-rule match vector with priority
//           snapshot, and selected result.
// Assumes : one global advance enable; a result that is not taken freezes
//           every stage, so latency is two cycles after acceptance when
//           the output is never held.
module mfm_matcher
    import mfm_pkg::*;
#(
    parameter int NUM_RULES = 8,
    parameter int PRIO_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_idx,
    input  logic               cfg_en,
    input  logic [ADDR_W-1:0]  cfg_sa,
    input  logic [LEN_W-1:0]   cfg_sa_len,
    input  logic [ADDR_W-1:0]  cfg_da,
    input  logic [LEN_W-1:0]   cfg_da_len,
    input  logic [PORT_W-1:0]  cfg_sp_lo,
    input  logic [PORT_W-1:0]  cfg_sp_hi,
    input  logic [PORT_W-1:0]  cfg_dp_lo,
    input  logic [PORT_W-1:0]  cfg_dp_hi,
    input  logic [PROTO_W-1:0] cfg_proto,
    input  logic               cfg_proto_any,
    input  logic [PRIO_W-1:0]  cfg_prio,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [ADDR_W-1:0]  in_sa,
    input  logic [ADDR_W-1:0]  in_da,
    input  logic [PORT_W-1:0]  in_sp,
    input  logic [PORT_W-1:0]  in_dp,
    input  logic [PROTO_W-1:0] in_proto,
    output logic               out_valid,
    input  logic               out_ready,
    output logic               out_hit,
    output logic [2:0]         out_idx,
    output logic [PRIO_W-1:0]  out_prio
);

    localparam int IDX_W = 3;

    rule_t                             wr_rule;
    rule_t [NUM_RULES-1:0]             rules;
    logic  [NUM_RULES-1:0][PRIO_W-1:0] prios;
    logic                              adv;

    // Stage 1: captured header.
    logic                              s1_v;
    hdr_t                              s1_hdr;
    // Stage 2: match vector and priority snapshot.
    logic                              s2_v;
    logic  [NUM_RULES-1:0]             s2_hit;
    logic  [NUM_RULES-1:0][PRIO_W-1:0] s2_prio;
    logic  [NUM_RULES-1:0]             hit_c;
    // Selector outputs.
    logic                              sel_found;
    logic  [IDX_W-1:0]                 sel_idx;
    logic  [PRIO_W-1:0]                sel_prio;

    // Pack the write port fields into one rule record.
    always_comb begin
        wr_rule.en        = cfg_en;
        wr_rule.sa        = cfg_sa;
        wr_rule.sa_len    = cfg_sa_len;
        wr_rule.da        = cfg_da;
        wr_rule.da_len    = cfg_da_len;
        wr_rule.sp_lo     = cfg_sp_lo;
        wr_rule.sp_hi     = cfg_sp_hi;
        wr_rule.dp_lo     = cfg_dp_lo;
        wr_rule.dp_hi     = cfg_dp_hi;
        wr_rule.proto     = cfg_proto;
        wr_rule.proto_any = cfg_proto_any;
    end

    mfm_rule_table #(
        .NUM_RULES (NUM_RULES),
        .PRIO_W    (PRIO_W),
        .IDX_W     (IDX_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_rule (wr_rule),
        .wr_prio (cfg_prio),
        .rules_o (rules),
        .prio_o  (prios)
    );

    // The pipeline moves unless a held result blocks the output.
    assign adv      = !(out_valid && !out_ready);
    assign in_ready = adv;

    // Stage 1: accept a header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v   <= 1'b0;
            s1_hdr <= '0;
        end else if (adv) begin
            s1_v <= in_valid;
            if (in_valid) begin
                s1_hdr.sa    <= in_sa;
                s1_hdr.da    <= in_da;
                s1_hdr.sp    <= in_sp;
                s1_hdr.dp    <= in_dp;
                s1_hdr.proto <= in_proto;
            end
        end
    end

    // One comparator per table entry.
    for (genvar g = 0; g < NUM_RULES; g++) begin : g_cmp
        mfm_rule_cmp u_cmp (
            .hdr  (s1_hdr),
            .rule (rules[g]),
            .hit  (hit_c[g])
        );
    end

    // Stage 2: register match vector and snapshot the priorities with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_v    <= 1'b0;
            s2_hit  <= '0;
            s2_prio <= '0;
        end else if (adv) begin
            s2_v    <= s1_v;
            s2_hit  <= s1_v ? hit_c : '0;
            s2_prio <= prios;
        end
    end

    mfm_prio_sel #(
        .NUM_RULES (NUM_RULES),
        .PRIO_W    (PRIO_W),
        .IDX_W     (IDX_W)
    ) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (s2_hit),
        .prio_i  (s2_prio),
        .found_o (sel_found),
        .idx_o   (sel_idx),
        .prio_o  (sel_prio)
    );

    // Stage 3: registered result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_idx   <= '0;
            out_prio  <= '0;
        end else if (adv) begin
            out_valid <= s2_v;
            out_hit   <= sel_found;
            out_idx   <= sel_idx;
            out_prio  <= sel_prio;
        end
    end

    // R8: a result that is not taken stays on the outputs unchanged
    a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_hit) && $stable(out_idx) && $stable(out_prio)));

    // R7: an accepted request reaches stage 1 at the next edge
    a_r7_accept_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> s1_v);

    // R7: a request in stage 2 reaches the outputs when the pipeline moves
    a_r7_stage2_to_out: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_v && adv) |=> out_valid);

    // R6: a miss reports zero index and zero priority
    a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hit) |-> ((out_idx == '0) && (out_prio == '0)));

endmodule

// File: tb/mfm_matcher_tb.sv
module mfm_matcher_tb;

    localparam int NR = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_idx = '0;
    logic       cfg_en = 1'b0;
    logic [7:0] cfg_sa = '0, cfg_da = '0;
    logic [3:0] cfg_sa_len = '0, cfg_da_len = '0;
    logic [3:0] cfg_sp_lo = '0, cfg_sp_hi = '0, cfg_dp_lo = '0, cfg_dp_hi = '0;
    logic [1:0] cfg_proto = '0;
    logic       cfg_proto_any = 1'b0;
    logic [3:0] cfg_prio = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_sa = '0, in_da = '0;
    logic [3:0] in_sp = '0, in_dp = '0;
    logic [1:0] in_proto = '0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic       out_hit;
    logic [2:0] out_idx;
    logic [3:0] out_prio;

    mfm_matcher u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
        .cfg_sa(cfg_sa), .cfg_sa_len(cfg_sa_len),
        .cfg_da(cfg_da), .cfg_da_len(cfg_da_len),
        .cfg_sp_lo(cfg_sp_lo), .cfg_sp_hi(cfg_sp_hi),
        .cfg_dp_lo(cfg_dp_lo), .cfg_dp_hi(cfg_dp_hi),
        .cfg_proto(cfg_proto), .cfg_proto_any(cfg_proto_any), .cfg_prio(cfg_prio),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_sa(in_sa), .in_da(in_da), .in_sp(in_sp), .in_dp(in_dp), .in_proto(in_proto),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_hit(out_hit), .out_idx(out_idx), .out_prio(out_prio)
    );

    always #5 clk = ~clk;   // 100 MHz

    int n_chk = 0;
    int n_bad = 0;
    int edges = 0;
    bit lat_chk = 1'b0;
    bit mon_on = 1'b0;

    // Reference rule model.
    bit       m_en[NR];
    bit [7:0] m_sa[NR], m_da[NR];
    bit [3:0] m_sal[NR], m_dal[NR], m_spl[NR], m_sph[NR], m_dpl[NR], m_dph[NR], m_pri[NR];
    bit [1:0] m_pr[NR];
    bit       m_pany[NR];

    // Expected results in flight.
    int q_hit[$], q_idx[$], q_pri[$], q_due[$];

    // Most recent directed result.
    int r_hit, r_idx, r_pri;

    task automatic chk(input string req, input bit ok, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit pfx(input bit [7:0] key, input bit [7:0] val, input bit [3:0] len);
        int l;
        l = (len > 8) ? 8 : int'(len);
        if (l == 0) return 1'b1;
        return (key >> (8 - l)) == (val >> (8 - l));
    endfunction

    function automatic void model(input bit [7:0] sa, input bit [7:0] da, input bit [3:0] sp,
                                  input bit [3:0] dp, input bit [1:0] pr,
                                  output int h, output int idx, output int pri);
        h = 0; idx = 0; pri = 0;
        for (int i = 0; i < NR; i++) begin
            if (m_en[i] && pfx(sa, m_sa[i], m_sal[i]) && pfx(da, m_da[i], m_dal[i]) &&
                sp >= m_spl[i] && sp <= m_sph[i] && dp >= m_dpl[i] && dp <= m_dph[i] &&
                (m_pany[i] || pr == m_pr[i])) begin
                if (h == 0 || int'(m_pri[i]) < pri) begin
                    h = 1; idx = i; pri = int'(m_pri[i]);
                end
            end
        end
    endfunction

    always @(posedge clk) edges <= edges + 1;

    // Monitor: checks every taken result against the model, and the hold rule.
    bit       p_stall = 1'b0;
    bit       p_hit;
    bit [2:0] p_idx;
    bit [3:0] p_pri;
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid && out_ready) begin
                if (q_hit.size() == 0) begin
                    chk("R7", 1'b0, "result with no request", 1, 0);
                end else begin
                    int eh, ei, ep, ed;
                    eh = q_hit.pop_front(); ei = q_idx.pop_front();
                    ep = q_pri.pop_front(); ed = q_due.pop_front();
                    chk("R4", out_hit == eh[0], "hit", int'(out_hit), eh);
                    chk("R5", int'(out_idx) == ei, "idx", int'(out_idx), ei);
                    chk("R5", int'(out_prio) == ep, "prio", int'(out_prio), ep);
                    if (lat_chk) chk("R7", edges == ed, "result edge", edges, ed);
                end
            end
            if (out_valid && !out_ready) begin
                chk("R8", in_ready == 1'b0, "in_ready under stall", int'(in_ready), 0);
                if (p_stall) begin
                    chk("R8", out_hit == p_hit, "held hit", int'(out_hit), int'(p_hit));
                    chk("R8", out_idx == p_idx, "held idx", int'(out_idx), int'(p_idx));
                    chk("R8", out_prio == p_pri, "held prio", int'(out_prio), int'(p_pri));
                end
            end
            p_stall = out_valid && !out_ready;
            p_hit = out_hit; p_idx = out_idx; p_pri = out_prio;
            if (in_valid && in_ready) begin
                int h, i, p;
                model(in_sa, in_da, in_sp, in_dp, in_proto, h, i, p);
                q_hit.push_back(h); q_idx.push_back(i); q_pri.push_back(p);
                q_due.push_back(edges + 3);
            end
        end
    end

    task automatic wr(input int i, input bit en, input bit [7:0] sa, input bit [3:0] sal,
                      input bit [7:0] da, input bit [3:0] dal,
                      input bit [3:0] spl, input bit [3:0] sph,
                      input bit [3:0] dpl, input bit [3:0] dph,
                      input bit [1:0] pr, input bit pany, input bit [3:0] pri);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_idx = 3'(i); cfg_en = en;
        cfg_sa = sa; cfg_sa_len = sal; cfg_da = da; cfg_da_len = dal;
        cfg_sp_lo = spl; cfg_sp_hi = sph; cfg_dp_lo = dpl; cfg_dp_hi = dph;
        cfg_proto = pr; cfg_proto_any = pany; cfg_prio = pri;
        m_en[i] = en; m_sa[i] = sa; m_sal[i] = sal; m_da[i] = da; m_dal[i] = dal;
        m_spl[i] = spl; m_sph[i] = sph; m_dpl[i] = dpl; m_dph[i] = dph;
        m_pr[i] = pr; m_pany[i] = pany; m_pri[i] = pri;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic lookup(input bit [7:0] sa, input bit [7:0] da, input bit [3:0] sp,
                          input bit [3:0] dp, input bit [1:0] pr);
        @(posedge clk); #1;
        in_valid = 1'b1; in_sa = sa; in_da = da; in_sp = sp; in_dp = dp; in_proto = pr;
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(posedge clk);
        @(posedge clk); #1;
        chk("R7", out_valid == 1'b1, "out_valid two edges after accept", int'(out_valid), 1);
        r_hit = int'(out_hit); r_idx = int'(out_idx); r_pri = int'(out_prio);
        repeat (2) @(posedge clk);
    endtask

    task automatic stream(input int n, input bit bp);
        @(posedge clk); #1;
        lat_chk = !bp;
        for (int c = 0; c < n; c++) begin
            in_valid = ($urandom % 10) < 7;
            in_sa = 8'($urandom); in_da = 8'($urandom);
            in_sp = 4'($urandom); in_dp = 4'($urandom); in_proto = 2'($urandom);
            out_ready = bp ? (($urandom % 3) != 0) : 1'b1;
            @(posedge clk); #1;
        end
        in_valid = 1'b0; out_ready = 1'b1;
        repeat (6) @(posedge clk);
        #1 lat_chk = 1'b0;
    endtask

    task automatic rand_rules();
        for (int i = 0; i < NR; i++) begin
            bit [3:0] a, b, c, d;
            a = 4'($urandom); b = 4'($urandom); c = 4'($urandom); d = 4'($urandom);
            if (($urandom % 4) != 0) begin
                if (a > b) begin bit [3:0] t; t = a; a = b; b = t; end
                if (c > d) begin bit [3:0] t; t = c; c = d; d = t; end
            end
            wr(i, ($urandom % 8) != 0, 8'($urandom), (($urandom % 6) == 0) ? 4'd12 : 4'($urandom % 4),
               8'($urandom), 4'($urandom % 4), a, b, c, d, 2'($urandom), 1'($urandom), 4'($urandom % 4));
        end
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NR; i++) begin
            m_en[i] = 0; m_sa[i] = 0; m_sal[i] = 0; m_da[i] = 0; m_dal[i] = 0;
            m_spl[i] = 0; m_sph[i] = 0; m_dpl[i] = 0; m_dph[i] = 0;
            m_pr[i] = 0; m_pany[i] = 0; m_pri[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R10", out_valid == 1'b0, "out_valid after reset", int'(out_valid), 0);
        chk("R10", in_ready == 1'b1, "in_ready after reset", int'(in_ready), 1);
        mon_on = 1'b1;

        // R10: empty table gives no match; R6 zero fields
        lookup(8'h80, 8'h34, 4'd2, 4'd6, 2'd3);
        chk("R10", r_hit == 0, "hit on empty table", r_hit, 0);
        chk("R6", r_idx == 0 && r_pri == 0, "miss idx/prio", r_idx * 16 + r_pri, 0);

        // R5: priority beats position; prio-3 rule at index 2, prio-2 rule at index 5
        wr(2, 1, 8'h80, 4'd2, 8'h30, 4'd4, 4'd0, 4'd3, 4'd6, 4'd7, 2'd3, 0, 4'd3);
        wr(5, 1, 8'h80, 4'd3, 8'h00, 4'd2, 4'd2, 4'd5, 4'd6, 4'd7, 2'd3, 0, 4'd2);
        lookup(8'h80, 8'h34, 4'd2, 4'd6, 2'd3);
        chk("R5", r_hit == 1 && r_idx == 5, "priority over position idx", r_idx, 5);
        chk("R5", r_pri == 2, "winning prio", r_pri, 2);

        // R5: equal priority at index 6, lower index keeps the win
        wr(6, 1, 8'h00, 4'd0, 8'h00, 4'd0, 4'd0, 4'd15, 4'd0, 4'd15, 2'd0, 1, 4'd2);
        lookup(8'h80, 8'h34, 4'd2, 4'd6, 2'd3);
        chk("R5", r_idx == 5, "tie goes to lower index", r_idx, 5);

        // R4 and R9: disabling entry 5 hands the win to index 6
        wr(5, 0, 8'h80, 4'd3, 8'h00, 4'd2, 4'd2, 4'd5, 4'd6, 4'd7, 2'd3, 0, 4'd2);
        lookup(8'h80, 8'h34, 4'd2, 4'd6, 2'd3);
        chk("R4", r_idx == 6, "disabled rule skipped", r_idx, 6);

        // R3: exact protocol mismatch fails rule 2, wildcard rule 6 still hits
        wr(6, 0, 8'h00, 4'd0, 8'h00, 4'd0, 4'd0, 4'd15, 4'd0, 4'd15, 2'd0, 1, 4'd2);
        lookup(8'h80, 8'h34, 4'd2, 4'd6, 2'd1);
        chk("R3", r_hit == 0, "protocol mismatch", r_hit, 0);
        wr(6, 1, 8'h00, 4'd0, 8'h00, 4'd0, 4'd0, 4'd15, 4'd0, 4'd15, 2'd0, 1, 4'd9);
        lookup(8'h11, 8'h22, 4'd9, 4'd1, 2'd1);
        chk("R3", r_hit == 1 && r_idx == 6, "protocol wildcard", r_idx, 6);

        // R2: inverted range never matches; full range matches boundaries
        wr(6, 1, 8'h00, 4'd0, 8'h00, 4'd0, 4'd9, 4'd3, 4'd0, 4'd15, 2'd0, 1, 4'd1);
        lookup(8'h11, 8'h22, 4'd5, 4'd15, 2'd1);
        chk("R2", r_hit == 0, "inverted range", r_hit, 0);
        wr(6, 1, 8'h00, 4'd0, 8'h00, 4'd0, 4'd0, 4'd15, 4'd15, 4'd15, 2'd0, 1, 4'd1);
        lookup(8'h11, 8'h22, 4'd15, 4'd15, 2'd1);
        chk("R2", r_hit == 1, "range edge hit", r_hit, 1);

        // R1: length above 8 acts as 8; one bit off misses
        wr(6, 1, 8'hA5, 4'd13, 8'h00, 4'd0, 4'd0, 4'd15, 4'd0, 4'd15, 2'd0, 1, 4'd1);
        lookup(8'hA5, 8'h22, 4'd1, 4'd1, 2'd1);
        chk("R1", r_hit == 1, "long length exact", r_hit, 1);
        lookup(8'hA4, 8'h22, 4'd1, 4'd1, 2'd1);
        chk("R1", r_hit == 0, "long length one bit off", r_hit, 0);

        // Random phases: R7 latency without backpressure, R8 with it
        for (int k = 0; k < 4; k++) begin
            rand_rules();
            stream(400, 1'b0);
            stream(400, 1'b1);
        end

        // R10: reset clears the table
        @(posedge clk); #1 rst_n = 1'b0;
        for (int i = 0; i < NR; i++) m_en[i] = 0;
        mon_on = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        lookup(8'h80, 8'h34, 4'd2, 4'd6, 2'd3);
        chk("R10", r_hit == 0, "hit after second reset", r_hit, 0);

        repeat (4) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule